// File: doc/BRIEF.md
# Invalidation Queue Descriptor Processor

This block drains a circular queue of 128-bit invalidation descriptors kept in memory. Software sets up the queue location and size through a queue-address register and adds work by moving the tail index. Whenever the tail differs from the head and no queue error is pending, the engine fetches the descriptor at the head. It decodes the type and carries out the action for that type, then moves the head forward by one. When the head reaches the end of the queue it wraps back to entry 0.

Two descriptor types are understood. An interrupt-cache invalidation retires with no further action, because the cache flush happens outside this block. A wait descriptor can ask for a 32-bit status word to be written to memory. That request leaves on a valid/ready port. Once `sw_valid` rises, the request holds its address and data steady until `sw_ready` is seen high on a clock edge, and the head does not move while the request is stalled. Any other type halts the walk with the head left on the offending entry and sets a sticky queue-error flag. No fetch takes place while that flag is set.

Descriptors are read through a simple port. `mem_rd_data` must carry the entry exactly one cycle after the cycle in which `mem_rd_en` is high.

Top module: `iq_desc_proc`

## Requirements
- R1: After reset the head, tail and queue-address values are zero, the error flag is clear, and neither a read nor a status write is requested.
- R2: A register write with select 0 is a tail write. When it is accepted, the tail index becomes bits 18:4 of the written value.
- R3: A tail write that has any bit set outside bits 18:4 is discarded, and the tail does not change.
- R4: A tail write whose index is greater than or equal to the entry count is discarded. The entry count is 2 to the power (ENTRY_ORDER + queue-address bits 2:0).
- R5: A register write with select 1 is a queue-address write. It is discarded if any of bits 11:3 is set or any bit at or above ADDR_W is set. An accepted write stores the value and clears both head and tail to 0. The byte address of entry i is {value[63:12], 12'h000} + 16*i.
- R6: Entries are read in order from head toward tail, and the index wraps modulo the entry count. When head equals tail, no read is issued.
- R7: A descriptor whose low-quadword bits 3:0 equal 5 (interrupt-cache invalidation) retires, and the head advances by one.
- R8: A descriptor with type 4 (wait) and low-quadword bit 5 set issues one status write. The data is low-quadword bits 63:32. The address is high-quadword bits 63:2 followed by two zero bits. The request holds until it is accepted, and the head advances only after acceptance. A wait descriptor with bit 5 clear issues no status write and simply retires.
- R9: Any other type stops the walk. The head stays on the failing index and the error flag is set.
- R10: While the error flag is set, no read is issued. A register write with select 2 and bit 4 set clears the flag, and the walk then resumes. Such a write with bit 4 clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | 0 tail, 1 queue address, 2 fault clear |
| reg_wr_data | input | 64 | Register write value |
| head_idx | output | 15 | Current head index |
| tail_idx | output | 15 | Current tail index |
| qaddr | output | 64 | Queue-address register |
| qerr | output | 1 | Sticky queue-error flag |
| mem_rd_en | output | 1 | Descriptor read request |
| mem_rd_addr | output | 64 | Descriptor byte address |
| mem_rd_data | input | 128 | Descriptor, valid one cycle after the request |
| sw_valid | output | 1 | Status write request valid |
| sw_ready | input | 1 | Status write accepted |
| sw_addr | output | 64 | Status write byte address |
| sw_data | output | 32 | Status write data |

## Verification
The bench builds the block with ENTRY_ORDER = 2 and ADDR_W = 39. With these values a size field of 0 gives a 4-entry queue and a size field of 1 gives an 8-entry queue. That makes index wrap-around and the out-of-range tail rejection reachable within a few dozen cycles. It also places the address-width limit at bit 39, so an upper-bit rejection can be tried without a 64-bit-wide address space. The bench's memory model only needs 16 descriptor slots.

// File: rtl/iq_pkg.sv
package iq_pkg;
  localparam int IDX_W       = 15;
  localparam int IDX_LSB     = 4;
  localparam int QERR_BIT    = 4;
  localparam int SWFLAG_BIT  = 5;
  localparam logic [3:0] DT_WAIT = 4'd4;
  localparam logic [3:0] DT_IEC  = 4'd5;

  typedef enum logic [1:0] {
    SEL_TAIL  = 2'd0,
    SEL_QADDR = 2'd1,
    SEL_FCLR  = 2'd2
  } reg_sel_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_DECODE,
    ST_STATUS
  } walk_st_t;
endpackage

// File: rtl/iq_regs.sv
module iq_regs
  import iq_pkg::*;
#(
  parameter int ENTRY_ORDER = 8,
  parameter int ADDR_W      = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [63:0]      wr_data,
  input  logic             err_set,
  output logic [IDX_W-1:0] tail_idx,
  output logic [63:0]      qaddr,
  output logic             qerr,
  output logic             qa_accept,
  output logic [IDX_W-1:0] entry_mask
);
  localparam logic [63:0] HI_MASK  = ~((64'd1 << ADDR_W) - 64'd1);
  localparam logic [63:0] IDX_MASK = ((64'd1 << IDX_W) - 64'd1) << IDX_LSB;

  logic [IDX_W:0]   entry_cnt;
  logic [IDX_W-1:0] wr_idx;
  logic             tail_ok, qa_ok, fclr;

  assign entry_cnt  = {{IDX_W{1'b0}}, 1'b1} << (ENTRY_ORDER + int'(qaddr[2:0]));
  assign entry_mask = IDX_W'(entry_cnt - 1'b1);
  assign wr_idx     = wr_data[IDX_LSB +: IDX_W];

  assign tail_ok   = ((wr_data & ~IDX_MASK) == 64'd0) && ({1'b0, wr_idx} < entry_cnt);
  assign qa_ok     = (wr_data[11:3] == 9'd0) && ((wr_data & HI_MASK) == 64'd0);
  assign qa_accept = wr_en && (reg_sel_t'(wr_sel) == SEL_QADDR) && qa_ok;
  assign fclr      = wr_en && (reg_sel_t'(wr_sel) == SEL_FCLR) && wr_data[QERR_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tail_idx <= '0;
      qaddr    <= '0;
      qerr     <= 1'b0;
    end else begin
      if (qa_accept) begin
        qaddr    <= wr_data;
        tail_idx <= '0;
      end else if (wr_en && (reg_sel_t'(wr_sel) == SEL_TAIL) && tail_ok) begin
        tail_idx <= wr_idx;
      end
      if (err_set)   qerr <= 1'b1;
      else if (fclr) qerr <= 1'b0;
    end
  end

  // R4: the tail never points outside the current queue
  a_r4_tail_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, tail_idx} < entry_cnt);

  // R5: an address write with a reserved bit set leaves the register alone
  a_r5_qa_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd1 && wr_data[3]) |=> $stable(qaddr));

  // R3: a tail write with bit 0 set is dropped
  a_r3_tail_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd0 && wr_data[0]) |=> $stable(tail_idx));
endmodule

// File: rtl/iq_desc_dec.sv
module iq_desc_dec
  import iq_pkg::*;
(
  input  logic [127:0] desc,
  output logic         is_bad,
  output logic         sw_req,
  output logic [63:0]  sw_addr,
  output logic [31:0]  sw_data
);
  logic [3:0] dtype;
  logic       known;

  assign dtype   = desc[3:0];
  assign known   = (dtype == DT_WAIT) || (dtype == DT_IEC);
  assign is_bad  = !known;
  assign sw_req  = (dtype == DT_WAIT) && desc[SWFLAG_BIT];
  assign sw_data = desc[63:32];
  assign sw_addr = {desc[127:66], 2'b00};
endmodule

// File: rtl/iq_walker.sv
module iq_walker
  import iq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] tail_idx,
  input  logic [63:0]      qaddr,
  input  logic             qerr,
  input  logic             qa_accept,
  input  logic [IDX_W-1:0] entry_mask,
  input  logic             d_bad,
  input  logic             d_sw_req,
  input  logic [63:0]      d_sw_addr,
  input  logic [31:0]      d_sw_data,
  input  logic             sw_ready,
  output logic [IDX_W-1:0] head_idx,
  output logic             mem_rd_en,
  output logic [63:0]      mem_rd_addr,
  output logic             sw_valid,
  output logic [63:0]      sw_addr,
  output logic [31:0]      sw_data,
  output logic             err_set
);
  walk_st_t         state;
  logic [IDX_W-1:0] head_nxt;

  assign head_nxt    = (head_idx + 1'b1) & entry_mask;
  assign mem_rd_en   = (state == ST_FETCH);
  assign mem_rd_addr = {qaddr[63:12], 12'h000} + (64'(head_idx) << IDX_LSB);
  assign sw_valid    = (state == ST_STATUS);
  assign err_set     = (state == ST_DECODE) && d_bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      head_idx <= '0;
      sw_addr  <= '0;
      sw_data  <= '0;
    end else if (qa_accept) begin
      state    <= ST_IDLE;
      head_idx <= '0;
    end else begin
      unique case (state)
        ST_IDLE:   if (!qerr && head_idx != tail_idx) state <= ST_FETCH;
        ST_FETCH:  state <= ST_DECODE;
        ST_DECODE: begin
          if (d_bad) begin
            state <= ST_IDLE;
          end else if (d_sw_req) begin
            sw_addr <= d_sw_addr;
            sw_data <= d_sw_data;
            state   <= ST_STATUS;
          end else begin
            head_idx <= head_nxt;
            state    <= ST_IDLE;
          end
        end
        ST_STATUS: if (sw_ready) begin
          head_idx <= head_nxt;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R10: no descriptor read while the error flag is up
  a_r10_no_fetch_in_error: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> !qerr);

  // R8: a stalled status write keeps its payload
  a_r8_sw_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_valid && !sw_ready && !qa_accept) |=> (sw_valid && $stable(sw_addr) && $stable(sw_data)));

  // R9: the head stays on the failing entry
  a_r9_head_parks: assert property (@(posedge clk) disable iff (!rst_n)
    (err_set && !qa_accept) |=> $stable(head_idx));

  // R6: the head only ever steps by one with wrap, or clears on a new address
  a_r6_head_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(head_idx) && !$past(qa_accept)) |->
      (head_idx == (($past(head_idx) + 1'b1) & entry_mask)));
endmodule

// File: rtl/iq_desc_proc.sv
module iq_desc_proc
  import iq_pkg::*;
#(
  parameter int ENTRY_ORDER = 8,
  parameter int ADDR_W      = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [1:0]        reg_wr_sel,
  input  logic [63:0]       reg_wr_data,
  output logic [IDX_W-1:0]  head_idx,
  output logic [IDX_W-1:0]  tail_idx,
  output logic [63:0]       qaddr,
  output logic              qerr,
  output logic              mem_rd_en,
  output logic [63:0]       mem_rd_addr,
  input  logic [127:0]      mem_rd_data,
  output logic              sw_valid,
  input  logic              sw_ready,
  output logic [63:0]       sw_addr,
  output logic [31:0]       sw_data
);
  logic             err_set, qa_accept;
  logic [IDX_W-1:0] entry_mask;
  logic             d_bad, d_sw_req;
  logic [63:0]      d_sw_addr;
  logic [31:0]      d_sw_data;

  iq_regs #(.ENTRY_ORDER(ENTRY_ORDER), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr_en), .wr_sel(reg_wr_sel), .wr_data(reg_wr_data),
    .err_set(err_set),
    .tail_idx(tail_idx), .qaddr(qaddr), .qerr(qerr),
    .qa_accept(qa_accept), .entry_mask(entry_mask)
  );

  iq_desc_dec u_dec (
    .desc(mem_rd_data),
    .is_bad(d_bad), .sw_req(d_sw_req),
    .sw_addr(d_sw_addr), .sw_data(d_sw_data)
  );

  iq_walker u_walk (
    .clk(clk), .rst_n(rst_n),
    .tail_idx(tail_idx), .qaddr(qaddr), .qerr(qerr),
    .qa_accept(qa_accept), .entry_mask(entry_mask),
    .d_bad(d_bad), .d_sw_req(d_sw_req),
    .d_sw_addr(d_sw_addr), .d_sw_data(d_sw_data),
    .sw_ready(sw_ready),
    .head_idx(head_idx),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .sw_valid(sw_valid), .sw_addr(sw_addr), .sw_data(sw_data),
    .err_set(err_set)
  );
endmodule

// File: tb/iq_desc_proc_tb.sv
module iq_desc_proc_tb;
  localparam logic [63:0] BASE = 64'h5000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_wr_en = 1'b0;
  logic [1:0]   reg_wr_sel = 2'd0;
  logic [63:0]  reg_wr_data = '0;
  logic [14:0]  head_idx, tail_idx;
  logic [63:0]  qaddr, mem_rd_addr, sw_addr;
  logic         qerr, mem_rd_en, sw_valid;
  logic [127:0] mem_rd_data = '0;
  logic         sw_ready = 1'b1;
  logic [31:0]  sw_data;

  logic [127:0] mem [16];
  int           fetch_cnt = 0;
  logic [63:0]  last_rd_addr = '0;
  int           sw_cnt = 0;
  logic [63:0]  last_sw_addr = '0;
  logic [31:0]  last_sw_data = '0;
  int           total = 0;
  int           bad = 0;
  bit           finished = 1'b0;

  always #10 clk = ~clk;

  iq_desc_proc #(.ENTRY_ORDER(2), .ADDR_W(39)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
    .head_idx(head_idx), .tail_idx(tail_idx), .qaddr(qaddr), .qerr(qerr),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .sw_valid(sw_valid), .sw_ready(sw_ready), .sw_addr(sw_addr), .sw_data(sw_data)
  );

  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rd_data  <= mem[4'((mem_rd_addr - BASE) >> 4)];
      fetch_cnt    <= fetch_cnt + 1;
      last_rd_addr <= mem_rd_addr;
    end
    if (sw_valid && sw_ready) begin
      sw_cnt       <= sw_cnt + 1;
      last_sw_addr <= sw_addr;
      last_sw_data <= sw_data;
    end
  end

  function automatic logic [127:0] d_iec();
    return {64'h0, 64'h5};
  endfunction

  function automatic logic [127:0] d_wait(bit sw, logic [31:0] dat, logic [63:0] adr);
    return {adr, dat, 26'h0, sw, 1'b0, 4'h4};
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [63:0] val);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = val;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic settle(string req);
    int n = 0;
    while (head_idx != tail_idx && !qerr && n < 300) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
    check(req, 64'(n >= 300), 64'd0);
  endtask

  task automatic t_reset();
    check("R1 head", 64'(head_idx), 0);
    check("R1 tail", 64'(tail_idx), 0);
    check("R1 qaddr", qaddr, 0);
    check("R1 qerr", 64'(qerr), 0);
    check("R1 sw_valid", 64'(sw_valid), 0);
    check("R6 no fetch when empty", 64'(fetch_cnt), 0);
  endtask

  task automatic t_addr();
    wr(2'd1, BASE | 64'h8);
    check("R5 reserved bit 3", qaddr, 0);
    wr(2'd1, BASE | (64'd1 << 39));
    check("R5 above width", qaddr, 0);
    wr(2'd1, BASE | 64'h1);
    check("R5 accepted", qaddr, BASE | 64'h1);
  endtask

  task automatic t_tail_and_walk();
    int f0;
    wr(2'd0, (64'd2 << 4) | 64'h1);
    check("R3 low reserved", 64'(tail_idx), 0);
    wr(2'd0, 64'd1 << 19);
    check("R3 high reserved", 64'(tail_idx), 0);
    wr(2'd0, 64'd8 << 4);
    check("R4 index at count", 64'(tail_idx), 0);
    f0 = fetch_cnt;
    wr(2'd0, 64'd7 << 4);
    check("R2 tail accepted", 64'(tail_idx), 7);
    settle("R7 walk finished");
    check("R7 head", 64'(head_idx), 7);
    check("R6 fetches", 64'(fetch_cnt - f0), 7);
    check("R5 entry address", last_rd_addr, BASE + 64'd96);
  endtask

  task automatic t_resize();
    int f0 = fetch_cnt;
    wr(2'd1, BASE);
    check("R5 head cleared", 64'(head_idx), 0);
    check("R5 tail cleared", 64'(tail_idx), 0);
    wr(2'd0, 64'd4 << 4);
    repeat (4) @(negedge clk);
    check("R4 small queue", 64'(tail_idx), 0);
    check("R6 no fetch", 64'(fetch_cnt - f0), 0);
  endtask

  task automatic t_wrap();
    wr(2'd0, 64'd3 << 4);
    settle("R6 to 3");
    check("R6 head 3", 64'(head_idx), 3);
    mem[3] = d_iec();
    mem[0] = d_wait(1'b1, 32'hCAFE_F00D, 64'h0000_0012_3456_789B);
    wr(2'd0, 64'd1 << 4);
    settle("R6 wrap");
    check("R6 wrapped head", 64'(head_idx), 1);
    check("R8 one write", 64'(sw_cnt), 1);
    check("R8 data", 64'(last_sw_data), 64'hCAFE_F00D);
    check("R8 address", last_sw_addr, 64'h0000_0012_3456_7898);
  endtask

  task automatic t_stall();
    mem[1] = d_wait(1'b1, 32'h1357_2468, 64'h40);
    @(negedge clk);
    sw_ready = 1'b0;
    wr(2'd0, 64'd2 << 4);
    repeat (10) @(negedge clk);
    check("R8 valid held", 64'(sw_valid), 1);
    check("R8 head waits", 64'(head_idx), 1);
    check("R8 stalled payload", 64'(sw_data), 64'h1357_2468);
    sw_ready = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 head after accept", 64'(head_idx), 2);
    check("R8 two writes", 64'(sw_cnt), 2);
  endtask

  task automatic t_no_sw();
    mem[2] = d_wait(1'b0, 32'hFFFF_FFFF, 64'h80);
    wr(2'd0, 64'd3 << 4);
    settle("R8 plain wait");
    check("R8 plain wait head", 64'(head_idx), 3);
    check("R8 no write", 64'(sw_cnt), 2);
  endtask

  task automatic t_error();
    int f0;
    mem[3] = {64'h0, 64'h7};
    mem[0] = d_iec();
    wr(2'd0, 64'd1 << 4);
    settle("R9 stop");
    check("R9 flag", 64'(qerr), 1);
    check("R9 head parked", 64'(head_idx), 3);
    f0 = fetch_cnt;
    repeat (20) @(negedge clk);
    check("R10 no fetch", 64'(fetch_cnt - f0), 0);
    wr(2'd2, 64'h0);
    check("R10 bit4 clear keeps flag", 64'(qerr), 1);
    mem[3] = d_iec();
    wr(2'd2, 64'h10);
    settle("R10 resume");
    check("R10 flag cleared", 64'(qerr), 0);
    check("R10 head after resume", 64'(head_idx), 1);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = d_iec();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_addr();
    t_tail_and_walk();
    t_resize();
    t_wrap();
    t_stall();
    t_no_sw();
    t_error();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule